// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits beside a ring of three-channel counter groups and decides, for every counter channel, which clock enable and which gate level that channel receives. Every channel holds two 3-bit selections, one for its clock and one for its gate. Software writes and reads them through a small register port addressed by channel number. The counters are not inside this block. Their outputs come back in as inputs, so that one channel can clock or gate another.

All logic runs on the 10 MHz system clock. The slower reference rates are made by a chain of decade dividers as single-cycle enable strobes, so no extra clock domain is created. Outside pins are brought in through two-flop synchronizers. Rising edges on the pins that can act as clocks become one-cycle enables. Because the groups form a ring, the first channel of group 0 takes its cascade sources from the last group.

Top module: `cgr_route_matrix`

## Requirements
- R1: After reset every clock selection and every gate selection reads back as 0.
- R2: A write stores the 3-bit value into the addressed channel's clock selection (write-kind 0) or gate selection (write-kind 1). The same channel and kind on the read port return it unchanged, for all eight codes, reserved ones included.
- R3: Clock code 1 gives an enable on every cycle. Codes 2, 3, 4 and 5 give one-cycle enables repeating every 10, 100, 1000 and 10000 cycles.
- R4: Clock code 0 turns a rising edge on the channel's own clock pin into exactly one enable cycle. A pin that goes high just before edge k gives the enable in the cycle after edge k+1.
- R5: Clock code 7 uses the shared clock pin of the channel's own group, with the same two-flop latency. The shared pin of another group has no effect.
- R6: Clock code 6 gives a one-cycle enable in the same cycle that the source counter output rises. For a channel in position 1 or 2, the source is the channel just before it in its group. For position 0, the source is position 2 of the preceding group, and group 0 follows the last group.
- R7: Gate code 0 holds the gate high, and gate code 1 holds it low.
- R8: Gate code 2 passes the channel's own gate pin through two flops. A pin that goes high just before edge k shows on the gate after edge k+1.
- R9: Gate code 3 gives the inverted output of one counter. For position 2, that counter is position 0 of the same group. For positions 0 and 1, it is position n+1 of the preceding group, with group 0 following the last group.
- R10: Gate codes 4 to 7 hold the gate low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_pin_i | input | NCH | Per-channel external clock pins, asynchronous |
| gate_pin_i | input | NCH | Per-channel external gate pins, asynchronous |
| grp_clk_pin_i | input | NUM_GRP | Shared external clock pin of each group, asynchronous |
| cnt_out_i | input | NCH | Counter outputs, channel g*3+n |
| wr_en_i | input | 1 | Write strobe |
| wr_gate_i | input | 1 | Write kind: 0 clock selection, 1 gate selection |
| wr_chan_i | input | CHW | Channel written |
| wr_data_i | input | 3 | Selection code written |
| rd_gate_i | input | 1 | Read kind: 0 clock selection, 1 gate selection |
| rd_chan_i | input | CHW | Channel read |
| rd_data_o | output | 3 | Selection code read |
| clk_en_o | output | NCH | Per-channel clock enable |
| gate_o | output | NCH | Per-channel gate level |

## Verification
The gate path is tried from a vector table. Each entry pairs a gate code and a channel with a pattern of counter outputs. In the patterns, either only the expected source is high or everything except it is high. This separates correct ring routing from a neighbour that has been wired one channel off. The clock path is tried with isolated pin edges, checked cycle by cycle, to pin down the synchronizer latency and the pulse width. The shared-pin test drives one group's pin and watches a channel in the other group, which shows whether the group decode is correct. Counter-output edges at the ring seam cover the wrap from the last group to group 0. The prescaler is measured pulse to pulse at every decade, which catches a wrong modulus in any stage.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    localparam int CH_PER_GRP = 3;
    localparam int DECADES    = 4;

    typedef enum logic [2:0] {
        CLK_OWN_PIN = 3'd0,
        CLK_BASE    = 3'd1,
        CLK_DIV10   = 3'd2,
        CLK_DIV100  = 3'd3,
        CLK_DIV1K   = 3'd4,
        CLK_DIV10K  = 3'd5,
        CLK_CASCADE = 3'd6,
        CLK_GRP_PIN = 3'd7
    } clk_src_e;

    typedef enum logic [2:0] {
        GATE_ON      = 3'd0,
        GATE_OFF     = 3'd1,
        GATE_OWN_PIN = 3'd2,
        GATE_INV_OUT = 3'd3,
        GATE_RSV4    = 3'd4,
        GATE_RSV5    = 3'd5,
        GATE_RSV6    = 3'd6,
        GATE_RSV7    = 3'd7
    } gate_src_e;

    typedef struct packed {
        gate_src_e gate;
        clk_src_e  clk;
    } chan_sel_t;

    // Cascade clock source: previous channel, wrapping into the preceding group.
    function automatic int cascade_clk_src(int ch, int ngrp);
        int g = ch / CH_PER_GRP;
        int n = ch % CH_PER_GRP;
        if (n > 0) return ch - 1;
        return ((g + ngrp - 1) % ngrp) * CH_PER_GRP + (CH_PER_GRP - 1);
    endfunction

    // Inverted-output gate source: two positions back around the ring.
    function automatic int cascade_gate_src(int ch, int ngrp);
        int g = ch / CH_PER_GRP;
        int n = ch % CH_PER_GRP;
        if (n == CH_PER_GRP - 1) return g * CH_PER_GRP;
        return ((g + ngrp - 1) % ngrp) * CH_PER_GRP + n + 1;
    endfunction

endpackage

// File: rtl/cgr_decade_chain.sv
module cgr_decade_chain #(
    parameter int DECADES = 4
) (
    input  logic               clk,
    input  logic               rst,
    output logic [DECADES-1:0] tick_o
);
    logic [DECADES-1:0] at_nine;

    for (genvar k = 0; k < DECADES; k++) begin : g_stage
        logic [3:0] cnt_q;
        logic       adv;

        if (k == 0) begin : g_first
            assign adv = 1'b1;
        end else begin : g_rest
            assign adv = &at_nine[k-1:0];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= 4'd0;
            end else if (adv) begin
                cnt_q <= (cnt_q == 4'd9) ? 4'd0 : cnt_q + 4'd1;
            end
        end

        assign at_nine[k] = (cnt_q == 4'd9);
        assign tick_o[k]  = &at_nine[k:0];
    end
endmodule

// File: rtl/cgr_pin_sync.sv
module cgr_pin_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_o  <= '0;
        end else begin
            meta_q <= pin_i;
            lvl_o  <= meta_q;
        end
    end
endmodule

// File: rtl/cgr_rise_det.sv
module cgr_rise_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~last_q;
endmodule

// File: rtl/cgr_chan_route.sv
module cgr_chan_route
    import cgr_pkg::*;
#(
    parameter int DECADES = 4
) (
    input  chan_sel_t          sel_i,
    input  logic               own_rise_i,
    input  logic               grp_rise_i,
    input  logic               casc_rise_i,
    input  logic [DECADES-1:0] dec_tick_i,
    input  logic               gate_pin_i,
    input  logic               far_out_i,
    output logic               clk_en_o,
    output logic               gate_o
);
    always_comb begin
        unique case (sel_i.clk)
            CLK_OWN_PIN: clk_en_o = own_rise_i;
            CLK_BASE:    clk_en_o = 1'b1;
            CLK_DIV10:   clk_en_o = dec_tick_i[0];
            CLK_DIV100:  clk_en_o = dec_tick_i[1];
            CLK_DIV1K:   clk_en_o = dec_tick_i[2];
            CLK_DIV10K:  clk_en_o = dec_tick_i[3];
            CLK_CASCADE: clk_en_o = casc_rise_i;
            CLK_GRP_PIN: clk_en_o = grp_rise_i;
            default:     clk_en_o = 1'b0;
        endcase
    end

    always_comb begin
        unique case (sel_i.gate)
            GATE_ON:      gate_o = 1'b1;
            GATE_OFF:     gate_o = 1'b0;
            GATE_OWN_PIN: gate_o = gate_pin_i;
            GATE_INV_OUT: gate_o = ~far_out_i;
            default:      gate_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cgr_route_matrix.sv
module cgr_route_matrix
    import cgr_pkg::*;
#(
    parameter  int NUM_GRP = 2,
    localparam int NCH     = NUM_GRP * CH_PER_GRP,
    localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH-1:0]     clk_pin_i,
    input  logic [NCH-1:0]     gate_pin_i,
    input  logic [NUM_GRP-1:0] grp_clk_pin_i,
    input  logic [NCH-1:0]     cnt_out_i,
    input  logic               wr_en_i,
    input  logic               wr_gate_i,
    input  logic [CHW-1:0]     wr_chan_i,
    input  logic [2:0]         wr_data_i,
    input  logic               rd_gate_i,
    input  logic [CHW-1:0]     rd_chan_i,
    output logic [2:0]         rd_data_o,
    output logic [NCH-1:0]     clk_en_o,
    output logic [NCH-1:0]     gate_o
);
    chan_sel_t          sel_q [NCH];
    logic [NCH*6-1:0]   sel_flat;
    logic [DECADES-1:0] dec_tick;
    logic [NCH-1:0]     clk_pin_s, gate_pin_s, pin_rise, out_rise;
    logic [NUM_GRP-1:0] grp_pin_s, grp_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) sel_q[i] <= '0;
        end else if (wr_en_i && int'(wr_chan_i) < NCH) begin
            if (wr_gate_i) sel_q[wr_chan_i].gate <= gate_src_e'(wr_data_i);
            else           sel_q[wr_chan_i].clk  <= clk_src_e'(wr_data_i);
        end
    end

    always_comb begin
        rd_data_o = 3'd0;
        if (int'(rd_chan_i) < NCH) begin
            rd_data_o = rd_gate_i ? sel_q[rd_chan_i].gate : sel_q[rd_chan_i].clk;
        end
    end

    cgr_decade_chain #(.DECADES(DECADES)) u_div (
        .clk(clk), .rst(rst), .tick_o(dec_tick)
    );

    cgr_pin_sync #(.W(NCH)) u_sync_clk (
        .clk(clk), .rst(rst), .pin_i(clk_pin_i), .lvl_o(clk_pin_s)
    );
    cgr_pin_sync #(.W(NCH)) u_sync_gate (
        .clk(clk), .rst(rst), .pin_i(gate_pin_i), .lvl_o(gate_pin_s)
    );
    cgr_pin_sync #(.W(NUM_GRP)) u_sync_grp (
        .clk(clk), .rst(rst), .pin_i(grp_clk_pin_i), .lvl_o(grp_pin_s)
    );

    cgr_rise_det #(.W(NCH)) u_rise_pin (
        .clk(clk), .rst(rst), .lvl_i(clk_pin_s), .rise_o(pin_rise)
    );
    cgr_rise_det #(.W(NUM_GRP)) u_rise_grp (
        .clk(clk), .rst(rst), .lvl_i(grp_pin_s), .rise_o(grp_rise)
    );
    cgr_rise_det #(.W(NCH)) u_rise_out (
        .clk(clk), .rst(rst), .lvl_i(cnt_out_i), .rise_o(out_rise)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam int CSRC = cascade_clk_src(i, NUM_GRP);
        localparam int GSRC = cascade_gate_src(i, NUM_GRP);

        assign sel_flat[i*6 +: 6] = sel_q[i];

        cgr_chan_route #(.DECADES(DECADES)) u_route (
            .sel_i      (sel_q[i]),
            .own_rise_i (pin_rise[i]),
            .grp_rise_i (grp_rise[i / CH_PER_GRP]),
            .casc_rise_i(out_rise[CSRC]),
            .dec_tick_i (dec_tick),
            .gate_pin_i (gate_pin_s[i]),
            .far_out_i  (cnt_out_i[GSRC]),
            .clk_en_o   (clk_en_o[i]),
            .gate_o     (gate_o[i])
        );
    end
endmodule

// File: rtl/cgr_route_matrix_chk.sv
module cgr_route_matrix_chk #(
    parameter int NCH     = 6,
    parameter int DECADES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         rd_data,
    input logic [NCH*6-1:0]   sel_flat,
    input logic [DECADES-1:0] dec_tick,
    input logic [NCH-1:0]     pin_rise,
    input logic [NCH-1:0]     clk_en,
    input logic [NCH-1:0]     gate
);
    // R1: selections are cleared by reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_data == 3'd0));

    for (genvar k = 0; k < DECADES; k++) begin : g_tick
        // R3: each reference strobe lasts one cycle
        assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
            dec_tick[k] |=> !dec_tick[k]);
        if (k > 0) begin : g_nest
            // R3: a slower strobe only fires together with the faster one
            assert_tick_nested_R3: assert property (@(posedge clk) disable iff (rst)
                dec_tick[k] |-> dec_tick[k-1]);
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R4: a pin edge gives a single enable cycle
        assert_pin_pulse_R4: assert property (@(posedge clk) disable iff (rst)
            pin_rise[i] |=> !pin_rise[i]);
        // R3: base-rate selection enables every cycle
        assert_base_rate_R3: assert property (@(posedge clk) disable iff (rst)
            (sel_flat[i*6 +: 3] == 3'd1) |-> clk_en[i]);
        // R7: constant gate codes
        assert_gate_on_R7: assert property (@(posedge clk) disable iff (rst)
            (sel_flat[i*6+3 +: 3] == 3'd0) |-> gate[i]);
        assert_gate_off_R7: assert property (@(posedge clk) disable iff (rst)
            (sel_flat[i*6+3 +: 3] == 3'd1) |-> !gate[i]);
        // R10: reserved gate codes disable the gate
        assert_gate_rsv_R10: assert property (@(posedge clk) disable iff (rst)
            sel_flat[i*6+5] |-> !gate[i]);
    end
endmodule

bind cgr_route_matrix cgr_route_matrix_chk #(
    .NCH(NCH), .DECADES(cgr_pkg::DECADES)
) u_chk (
    .clk(clk), .rst(rst), .rd_data(rd_data_o), .sel_flat(sel_flat),
    .dec_tick(dec_tick), .pin_rise(pin_rise), .clk_en(clk_en_o), .gate(gate_o)
);

// File: tb/cgr_route_matrix_tb.sv
module cgr_route_matrix_tb;
    localparam int NUM_GRP = 2;
    localparam int NCH     = NUM_GRP * 3;
    localparam int CHW     = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NCH-1:0]     clk_pin = '0, gate_pin = '0, cnt_out = '0;
    logic [NUM_GRP-1:0] grp_pin = '0;
    logic               wr_en = 1'b0, wr_gate = 1'b0, rd_gate = 1'b0;
    logic [CHW-1:0]     wr_chan = '0, rd_chan = '0;
    logic [2:0]         wr_data = '0;
    logic [2:0]         rd_data;
    logic [NCH-1:0]     clk_en, gate;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cgr_route_matrix #(.NUM_GRP(NUM_GRP)) u_dut (
        .clk(clk), .rst(rst), .clk_pin_i(clk_pin), .gate_pin_i(gate_pin),
        .grp_clk_pin_i(grp_pin), .cnt_out_i(cnt_out), .wr_en_i(wr_en),
        .wr_gate_i(wr_gate), .wr_chan_i(wr_chan), .wr_data_i(wr_data),
        .rd_gate_i(rd_gate), .rd_chan_i(rd_chan), .rd_data_o(rd_data),
        .clk_en_o(clk_en), .gate_o(gate)
    );

    // Gate vectors: {chan[2:0], code[2:0], cnt_out[5:0], pad[2:0], expected gate}
    localparam int NV = 12;
    localparam logic [15:0] GVEC [NV] = '{
        {3'd0, 3'd0, 6'b000000, 3'b0, 1'b1},
        {3'd0, 3'd1, 6'b000000, 3'b0, 1'b0},
        {3'd0, 3'd3, 6'b010000, 3'b0, 1'b0},
        {3'd0, 3'd3, 6'b101111, 3'b0, 1'b1},
        {3'd1, 3'd3, 6'b100000, 3'b0, 1'b0},
        {3'd1, 3'd3, 6'b011111, 3'b0, 1'b1},
        {3'd2, 3'd3, 6'b000001, 3'b0, 1'b0},
        {3'd2, 3'd3, 6'b111110, 3'b0, 1'b1},
        {3'd3, 3'd3, 6'b000010, 3'b0, 1'b0},
        {3'd4, 3'd3, 6'b000100, 3'b0, 1'b0},
        {3'd5, 3'd4, 6'b000000, 3'b0, 1'b0},
        {3'd5, 3'd7, 6'b000000, 3'b0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic kind, input int ch, input logic [2:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_gate = kind; wr_chan = CHW'(ch); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic kind, input int ch, output logic [2:0] val);
        rd_gate = kind; rd_chan = CHW'(ch);
        #1 val = rd_data;
    endtask

    task automatic period_chk(input logic [2:0] code, input int expp, input string req);
        int n;
        wr(1'b0, 0, code);
        n = 0;
        while (!clk_en[0] && n < 30000) begin @(negedge clk); n++; end
        @(negedge clk);
        chk({req, " pulse width"}, int'(clk_en[0]), 0);
        n = 1;
        while (!clk_en[0] && n < 30000) begin @(negedge clk); n++; end
        chk({req, " period"}, n, expp);
    endtask

    function automatic string gate_req(input logic [2:0] code);
        if (code <= 3'd1) return "R7";
        if (code == 3'd3) return "R9";
        return "R10";
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [2:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every selection
        for (int c = 0; c < NCH; c++) begin
            rd(1'b0, c, v); chk("R1 clock sel after reset", int'(v), 0);
            rd(1'b1, c, v); chk("R1 gate sel after reset", int'(v), 0);
        end

        // R7 R9 R10 R2: gate vector table
        for (int i = 0; i < NV; i++) begin
            wr(1'b1, int'(GVEC[i][15:13]), GVEC[i][12:10]);
            cnt_out = GVEC[i][9:4];
            rd(1'b1, int'(GVEC[i][15:13]), v);
            chk({gate_req(GVEC[i][12:10]), " gate route"},
                int'(gate[GVEC[i][15:13]]), int'(GVEC[i][0]));
            chk("R2 gate readback", int'(v), int'(GVEC[i][12:10]));
        end
        cnt_out = '0;

        // R2: clock selection readback for every code
        for (int c = 0; c < 8; c++) begin
            wr(1'b0, 4, 3'(c));
            rd(1'b0, 4, v);
            chk("R2 clock readback", int'(v), c);
        end

        // R3: base rate enable held
        wr(1'b0, 1, 3'd1);
        begin
            int hi = 0;
            for (int k = 0; k < 5; k++) begin @(negedge clk); hi += int'(clk_en[1]); end
            chk("R3 base rate every cycle", hi, 5);
        end

        // R3: decade strobes
        period_chk(3'd2, 10, "R3 div10");
        period_chk(3'd3, 100, "R3 div100");
        period_chk(3'd4, 1000, "R3 div1k");
        period_chk(3'd5, 10000, "R3 div10k");

        // R4: own clock pin edge, two-flop latency, single cycle
        wr(1'b0, 2, 3'd0);
        @(negedge clk); clk_pin[2] = 1'b1;
        @(negedge clk); chk("R4 no enable after one edge", int'(clk_en[2]), 0);
        @(negedge clk); chk("R4 enable after two edges", int'(clk_en[2]), 1);
        @(negedge clk); chk("R4 single-cycle enable", int'(clk_en[2]), 0);
        clk_pin[2] = 1'b0;

        // R5: shared group pin reaches only its own group
        wr(1'b0, 3, 3'd7);
        wr(1'b0, 0, 3'd7);
        @(negedge clk); grp_pin[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 group 1 channel enabled", int'(clk_en[3]), 1);
        chk("R5 group 0 channel untouched", int'(clk_en[0]), 0);
        grp_pin[1] = 1'b0;

        // R6: cascade through the ring seam and inside a group
        wr(1'b0, 0, 3'd6);
        wr(1'b0, 4, 3'd6);
        @(negedge clk); cnt_out[5] = 1'b1;
        #1;
        chk("R6 ring wrap enable", int'(clk_en[0]), 1);
        chk("R6 unrelated channel quiet", int'(clk_en[4]), 0);
        @(negedge clk); chk("R6 single-cycle cascade", int'(clk_en[0]), 0);
        cnt_out[3] = 1'b1;
        #1 chk("R6 in-group cascade", int'(clk_en[4]), 1);
        @(negedge clk); cnt_out = '0;

        // R8: gate pin with two-flop latency
        wr(1'b1, 1, 3'd2);
        @(negedge clk); gate_pin[1] = 1'b1;
        @(negedge clk); chk("R8 gate pin after one edge", int'(gate[1]), 0);
        @(negedge clk); chk("R8 gate pin after two edges", int'(gate[1]), 1);

        // R1: reset in mid-run clears written selections
        wr(1'b1, 5, 3'd3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(1'b1, 5, v); chk("R1 gate sel cleared", int'(v), 0);
        rd(1'b0, 4, v); chk("R1 clock sel cleared", int'(v), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule